// File: doc/BRIEF.md
# USB Endpoint Handshake Mode Controller

This block decides how each endpoint of a low-speed USB device answers a host transaction. Firmware places a 4-bit mode code into each endpoint. When the packet engine reports a decoded token (SETUP, IN or OUT) together with the data-phase byte count, a CRC-good flag and the received data toggle, the block picks the handshake to return (ACK, NAK, STALL or none). It then moves the endpoint to its next mode by itself and records the packet status (byte count, data-valid bit and toggle).

Endpoint 0 is the control endpoint. It accepts a well-formed SETUP in any enabled mode and then holds a pending flag. While that flag is set, firmware cannot overwrite the mode, so the engine's result survives until firmware has read it. The other endpoints each carry a stall bit that overrides the mode for IN and OUT. Firmware reads all of this per-endpoint state through a registered read port. NRZI, bit stuffing and the CRC calculation happen upstream of this block.

Top module: `usb_ep_handshake`

## Requirements
- R1: After a synchronous reset every endpoint reads mode 0000 with stall, count, data-valid, toggle and the SETUP-pending flag all zero, and `hs_valid` is low.
- R2: An endpoint in mode 0000 (disabled) whose stall bit is clear returns no handshake and changes no state for any token.
- R3: An IN token with the stall bit clear is answered as follows. Mode 0001 gives NAK. Modes 0010 and 0011 give STALL. Modes 0110, 1000 and 1011 give ACK and the endpoint moves to 0001. Mode 1111 gives ACK and the endpoint moves to 0010.
- R4: A valid OUT (CRC good, at most MAX_LEN bytes) with the stall bit clear is answered as follows. Modes 0001 and 1000 give NAK. Modes 0011 and 0110 give STALL. Mode 1011 gives ACK and moves to 1000. Modes 0010 and 1111 give ACK and move to 0001 for a zero-length packet, and give STALL for any other length. Every OUT that gets ACK stores its count, data-valid=1 and toggle.
- R5: An OUT or SETUP packet with a bad CRC or more than MAX_LEN bytes gets no handshake and leaves the mode unchanged. If the endpoint is not disabled, the packet's count and toggle are stored with data-valid=0.
- R6: A valid SETUP to endpoint 0 in any mode other than 0000 gets ACK, even in mode 0011. The endpoint moves to 0001, its count, data-valid=1 and toggle are stored, and the SETUP-pending flag is set. A SETUP to any other endpoint gets no handshake and changes nothing.
- R7: On endpoints other than 0, a set stall bit forces STALL for every valid IN or OUT, whatever the mode. On endpoint 0 the stall bit always reads 0.
- R8: While the SETUP-pending flag is set, firmware writes to endpoint 0 are dropped. A firmware read of endpoint 0 clears the flag.
- R9: When the engine changes an endpoint's mode in the same cycle that firmware writes that endpoint, the engine's mode is kept and the firmware write is dropped. If the engine does not change the mode in that cycle, the firmware write takes effect.
- R10: Mode codes outside the eight listed ones behave like 0001 (NAK for IN and valid OUT).
- R11: The handshake appears on `hs_valid`/`hs_code` one cycle after the token. Encodings: tokens SETUP=01, IN=10, OUT=11 (00 means no token); handshakes ACK=00, NAK=01, STALL=10. Read data appears one cycle after `fw_rd` and shows the state as it was before that edge.
- R12: Tokens and firmware accesses that name an endpoint number at or above NUM_EP produce no handshake and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Token event strobe |
| ev_kind | input | 2 | Token kind (01 SETUP, 10 IN, 11 OUT) |
| ev_ep | input | EP_W | Endpoint number of the token |
| ev_len | input | CNT_W | Data-phase byte count |
| ev_ok | input | 1 | Data-phase CRC good |
| ev_tgl | input | 1 | Received data toggle |
| fw_wr | input | 1 | Firmware write strobe |
| fw_rd | input | 1 | Firmware read strobe |
| fw_ep | input | EP_W | Endpoint for firmware access |
| fw_mode | input | 4 | Mode code to write |
| fw_stall | input | 1 | Stall bit to write |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_code | output | 2 | Handshake kind (00 ACK, 01 NAK, 10 STALL) |
| rd_mode | output | 4 | Mode read back |
| rd_stall | output | 1 | Stall bit read back |
| rd_cnt | output | CNT_W | Stored byte count |
| rd_dval | output | 1 | Stored data-valid bit |
| rd_tgl | output | 1 | Stored data toggle |
| rd_setup | output | 1 | SETUP-pending flag (endpoint 0 only) |

## Verification
A wrong stored mode only becomes visible at the ports when the next token reaches that endpoint, one cycle later, as the wrong handshake. Firmware can also see it on `rd_mode` one cycle after a read. For that reason every stimulus is followed immediately by a read of the same endpoint, so that a bad transition or a wrong count, data-valid or toggle update shows up within two cycles. A broken interlock can stay hidden until firmware reprograms endpoint 0. The bench therefore writes to endpoint 0 while a SETUP is pending, and writes in the same cycle as an engine update, and then reads the mode back.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

  typedef enum logic [3:0] {
    M_DISABLE     = 4'b0000,
    M_NAK_IO      = 4'b0001,
    M_ST_OUT      = 4'b0010,
    M_STALL_IO    = 4'b0011,
    M_ST_IN       = 4'b0110,
    M_NAK_OUT     = 4'b1000,
    M_ACKOUT_STIN = 4'b1011,
    M_ACKIN_STOUT = 4'b1111
  } ep_mode_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_SETUP = 2'b01,
    TK_IN    = 2'b10,
    TK_OUT   = 2'b11
  } tok_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;

  typedef struct packed {
    logic       hs_en;
    hs_e        hs;
    logic       mode_we;
    logic [3:0] mode_nx;
    logic       cnt_we;
    logic       pkt_good;
    logic       setup_set;
  } ep_verdict_t;

endpackage

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_hs_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MAX_LEN = 10
) (
  input  tok_e             kind,
  input  logic             is_ctrl,
  input  logic [3:0]       mode,
  input  logic             stall,
  input  logic [CNT_W-1:0] len,
  input  logic             ok,
  output ep_verdict_t      vd
);

  logic good;
  logic zero_len;
  logic enabled;

  assign good     = ok && (int'(len) <= MAX_LEN);
  assign zero_len = (len == '0);
  assign enabled  = (mode != M_DISABLE);

  always_comb begin
    vd           = '0;
    vd.hs        = HS_NAK;
    vd.mode_nx   = mode;
    vd.pkt_good  = good;
    case (kind)
      TK_SETUP: begin
        if (is_ctrl && enabled) begin
          vd.cnt_we = 1'b1;
          if (good) begin
            vd.hs_en     = 1'b1;
            vd.hs        = HS_ACK;
            vd.mode_we   = 1'b1;
            vd.mode_nx   = M_NAK_IO;
            vd.setup_set = 1'b1;
          end
        end
      end
      TK_IN: begin
        if (stall) begin
          vd.hs_en = 1'b1;
          vd.hs    = HS_STALL;
        end else begin
          case (mode)
            M_DISABLE: vd.hs_en = 1'b0;
            M_NAK_IO: begin
              vd.hs_en = 1'b1;
              vd.hs    = HS_NAK;
            end
            M_ST_OUT, M_STALL_IO: begin
              vd.hs_en = 1'b1;
              vd.hs    = HS_STALL;
            end
            M_ST_IN, M_NAK_OUT, M_ACKOUT_STIN: begin
              vd.hs_en   = 1'b1;
              vd.hs      = HS_ACK;
              vd.mode_we = 1'b1;
              vd.mode_nx = M_NAK_IO;
            end
            M_ACKIN_STOUT: begin
              vd.hs_en   = 1'b1;
              vd.hs      = HS_ACK;
              vd.mode_we = 1'b1;
              vd.mode_nx = M_ST_OUT;
            end
            default: begin
              vd.hs_en = 1'b1;
              vd.hs    = HS_NAK;
            end
          endcase
        end
      end
      TK_OUT: begin
        if (!good) begin
          vd.cnt_we = enabled;
        end else if (stall) begin
          vd.hs_en = 1'b1;
          vd.hs    = HS_STALL;
        end else begin
          case (mode)
            M_DISABLE: vd.hs_en = 1'b0;
            M_NAK_IO, M_NAK_OUT: begin
              vd.hs_en = 1'b1;
              vd.hs    = HS_NAK;
            end
            M_STALL_IO, M_ST_IN: begin
              vd.hs_en = 1'b1;
              vd.hs    = HS_STALL;
            end
            M_ACKOUT_STIN: begin
              vd.hs_en   = 1'b1;
              vd.hs      = HS_ACK;
              vd.mode_we = 1'b1;
              vd.mode_nx = M_NAK_OUT;
              vd.cnt_we  = 1'b1;
            end
            M_ST_OUT, M_ACKIN_STOUT: begin
              vd.hs_en = 1'b1;
              if (zero_len) begin
                vd.hs      = HS_ACK;
                vd.mode_we = 1'b1;
                vd.mode_nx = M_NAK_IO;
                vd.cnt_we  = 1'b1;
              end else begin
                vd.hs = HS_STALL;
              end
            end
            default: begin
              vd.hs_en = 1'b1;
              vd.hs    = HS_NAK;
            end
          endcase
        end
      end
      default: vd.hs_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/ep_hs_state.sv
module ep_hs_state #(
  parameter int NUM_EP = 3,
  parameter int CNT_W  = 4,
  parameter int EP_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          eng_en,
  input  logic [EP_W-1:0]               eng_ep,
  input  logic                          eng_mode_we,
  input  logic [3:0]                    eng_mode_nx,
  input  logic                          eng_cnt_we,
  input  logic                          eng_good,
  input  logic                          eng_setup,
  input  logic [CNT_W-1:0]              eng_len,
  input  logic                          eng_tgl,
  input  logic                          fw_wr,
  input  logic                          fw_rd,
  input  logic [EP_W-1:0]               fw_ep,
  input  logic [3:0]                    fw_mode,
  input  logic                          fw_stall,
  output logic [NUM_EP-1:0][3:0]        mode_q,
  output logic [NUM_EP-1:0]             stall_q,
  output logic [NUM_EP-1:0][CNT_W-1:0]  cnt_q,
  output logic [NUM_EP-1:0]             dval_q,
  output logic [NUM_EP-1:0]             tgl_q,
  output logic                          pend_q
);

  logic pend_r;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    localparam bit IS_CTRL = (g == 0);
    logic             eng_sel;
    logic             fw_take;
    logic [3:0]       mode_r;
    logic [CNT_W-1:0] cnt_r;
    logic             dval_r;
    logic             tgl_r;

    assign eng_sel = eng_en && (eng_ep == EP_W'(g));
    assign fw_take = fw_wr && (fw_ep == EP_W'(g))
                     && !(eng_sel && eng_mode_we)
                     && !(IS_CTRL && pend_r);

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_r <= '0;
        cnt_r  <= '0;
        dval_r <= 1'b0;
        tgl_r  <= 1'b0;
      end else begin
        if (eng_sel && eng_mode_we) mode_r <= eng_mode_nx;
        else if (fw_take)           mode_r <= fw_mode;
        if (eng_sel && eng_cnt_we) begin
          cnt_r  <= eng_len;
          dval_r <= eng_good;
          tgl_r  <= eng_tgl;
        end
      end
    end

    if (IS_CTRL) begin : g_ctrl
      assign stall_q[g] = 1'b0;
    end else begin : g_data
      logic stall_r;
      always_ff @(posedge clk) begin
        if (rst)          stall_r <= 1'b0;
        else if (fw_take) stall_r <= fw_stall;
      end
      assign stall_q[g] = stall_r;
    end

    assign mode_q[g] = mode_r;
    assign cnt_q[g]  = cnt_r;
    assign dval_q[g] = dval_r;
    assign tgl_q[g]  = tgl_r;
  end

  always_ff @(posedge clk) begin
    if (rst)                                       pend_r <= 1'b0;
    else if (eng_en && eng_ep == '0 && eng_setup)  pend_r <= 1'b1;
    else if (fw_rd && fw_ep == '0)                 pend_r <= 1'b0;
  end

  assign pend_q = pend_r;

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP  = 3,
  parameter int CNT_W   = 4,
  parameter int MAX_LEN = 10,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [EP_W-1:0]  ev_ep,
  input  logic [CNT_W-1:0] ev_len,
  input  logic             ev_ok,
  input  logic             ev_tgl,
  input  logic             fw_wr,
  input  logic             fw_rd,
  input  logic [EP_W-1:0]  fw_ep,
  input  logic [3:0]       fw_mode,
  input  logic             fw_stall,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic [3:0]       rd_mode,
  output logic             rd_stall,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_dval,
  output logic             rd_tgl,
  output logic             rd_setup
);

  logic [NUM_EP-1:0][3:0]       mode_q;
  logic [NUM_EP-1:0]            stall_q;
  logic [NUM_EP-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_EP-1:0]            dval_q;
  logic [NUM_EP-1:0]            tgl_q;
  logic                         pend_q;

  logic            ev_in_range;
  logic            fw_in_range;
  logic [EP_W-1:0] ev_idx;
  logic [EP_W-1:0] fw_idx;
  logic            eng_en;
  logic [3:0]      cur_mode;
  logic            cur_stall;
  tok_e            cur_kind;
  ep_verdict_t     vd;

  assign ev_in_range = (int'(ev_ep) < NUM_EP);
  assign fw_in_range = (int'(fw_ep) < NUM_EP);
  assign ev_idx      = ev_in_range ? ev_ep : '0;
  assign fw_idx      = fw_in_range ? fw_ep : '0;
  assign eng_en      = ev_valid && ev_in_range;
  assign cur_mode    = mode_q[ev_idx];
  assign cur_stall   = stall_q[ev_idx];
  assign cur_kind    = eng_en ? tok_e'(ev_kind) : TK_NONE;

  ep_hs_decide #(
    .CNT_W   (CNT_W),
    .MAX_LEN (MAX_LEN)
  ) i_decide (
    .kind    (cur_kind),
    .is_ctrl (ev_idx == '0),
    .mode    (cur_mode),
    .stall   (cur_stall),
    .len     (ev_len),
    .ok      (ev_ok),
    .vd      (vd)
  );

  ep_hs_state #(
    .NUM_EP (NUM_EP),
    .CNT_W  (CNT_W),
    .EP_W   (EP_W)
  ) i_state (
    .clk         (clk),
    .rst         (rst),
    .eng_en      (eng_en),
    .eng_ep      (ev_idx),
    .eng_mode_we (vd.mode_we),
    .eng_mode_nx (vd.mode_nx),
    .eng_cnt_we  (vd.cnt_we),
    .eng_good    (vd.pkt_good),
    .eng_setup   (vd.setup_set),
    .eng_len     (ev_len),
    .eng_tgl     (ev_tgl),
    .fw_wr       (fw_wr),
    .fw_rd       (fw_rd),
    .fw_ep       (fw_ep),
    .fw_mode     (fw_mode),
    .fw_stall    (fw_stall),
    .mode_q      (mode_q),
    .stall_q     (stall_q),
    .cnt_q       (cnt_q),
    .dval_q      (dval_q),
    .tgl_q       (tgl_q),
    .pend_q      (pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= 2'b00;
    end else begin
      hs_valid <= vd.hs_en;
      hs_code  <= vd.hs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_mode  <= '0;
      rd_stall <= 1'b0;
      rd_cnt   <= '0;
      rd_dval  <= 1'b0;
      rd_tgl   <= 1'b0;
      rd_setup <= 1'b0;
    end else if (fw_rd && fw_in_range) begin
      rd_mode  <= mode_q[fw_idx];
      rd_stall <= stall_q[fw_idx];
      rd_cnt   <= cnt_q[fw_idx];
      rd_dval  <= dval_q[fw_idx];
      rd_tgl   <= tgl_q[fw_idx];
      rd_setup <= (fw_idx == '0) && pend_q;
    end
  end

endmodule

// File: rtl/ep_hs_chk.sv
module ep_hs_chk #(
  parameter int NUM_EP  = 3,
  parameter int CNT_W   = 4,
  parameter int MAX_LEN = 10,
  parameter int EP_W    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic [1:0]       ev_kind,
  input logic [EP_W-1:0]  ev_ep,
  input logic [CNT_W-1:0] ev_len,
  input logic             ev_ok,
  input logic             fw_wr,
  input logic [EP_W-1:0]  fw_ep,
  input logic             hs_valid,
  input logic [1:0]       hs_code,
  input logic [3:0]       cur_mode,
  input logic             cur_stall,
  input logic [3:0]       ctl_mode,
  input logic             ctl_pend
);

  logic ep_ok;
  logic bad_pkt;
  assign ep_ok   = int'(ev_ep) < NUM_EP;
  assign bad_pkt = !ev_ok || (int'(ev_len) > MAX_LEN);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hs_valid); // R1

  AST_DISABLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ep_ok && cur_mode == 4'b0000 && !cur_stall) |=> !hs_valid); // R2

  AST_BAD_PKT_NO_HS: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 2'b11 && bad_pkt) |=> !hs_valid); // R5

  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 2'b01 && ev_ep == '0 && !bad_pkt && cur_mode != 4'b0000)
    |=> (hs_valid && hs_code == 2'b00)); // R6

  AST_STALL_FORCE: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ep_ok && ev_kind == 2'b10 && cur_stall)
    |=> (hs_valid && hs_code == 2'b10)); // R7

  AST_SETUP_LOCK: assert property (@(posedge clk) disable iff (rst)
    (ctl_pend && fw_wr && fw_ep == '0 && !ev_valid) |=> $stable(ctl_mode)); // R8

  AST_HS_FOLLOWS_TOKEN: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> $past(ev_valid && ev_kind != 2'b00)); // R11

  AST_FAR_EP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ep_ok) |=> !hs_valid); // R12

endmodule

bind usb_ep_handshake ep_hs_chk #(
  .NUM_EP  (NUM_EP),
  .CNT_W   (CNT_W),
  .MAX_LEN (MAX_LEN),
  .EP_W    (EP_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .ev_valid  (ev_valid),
  .ev_kind   (ev_kind),
  .ev_ep     (ev_ep),
  .ev_len    (ev_len),
  .ev_ok     (ev_ok),
  .fw_wr     (fw_wr),
  .fw_ep     (fw_ep),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .cur_mode  (cur_mode),
  .cur_stall (cur_stall),
  .ctl_mode  (mode_q[0]),
  .ctl_pend  (pend_q)
);

// File: tb/test_usb_ep_handshake.sv
module test_usb_ep_handshake;

  localparam int NEP = 3;

  logic       clk = 1'b0;
  logic       rst;
  logic       ev_valid, ev_ok, ev_tgl, fw_wr, fw_rd, fw_stall;
  logic [1:0] ev_kind;
  logic [1:0] ev_ep, fw_ep;
  logic [3:0] ev_len, fw_mode;
  logic       hs_valid, rd_stall, rd_dval, rd_tgl, rd_setup;
  logic [1:0] hs_code;
  logic [3:0] rd_mode, rd_cnt;

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0] m_mode [NEP];
  logic       m_stall[NEP];
  logic [3:0] m_cnt  [NEP];
  logic       m_dval [NEP];
  logic       m_tgl  [NEP];
  logic       m_pend;

  always #4 clk = ~clk;

  usb_ep_handshake i_usb_ep_handshake (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_ep(ev_ep),
    .ev_len(ev_len), .ev_ok(ev_ok), .ev_tgl(ev_tgl), .fw_wr(fw_wr), .fw_rd(fw_rd),
    .fw_ep(fw_ep), .fw_mode(fw_mode), .fw_stall(fw_stall), .hs_valid(hs_valid),
    .hs_code(hs_code), .rd_mode(rd_mode), .rd_stall(rd_stall), .rd_cnt(rd_cnt),
    .rd_dval(rd_dval), .rd_tgl(rd_tgl), .rd_setup(rd_setup)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected response from R2..R7, R10, R12
  function automatic void expect_resp(input int ep, input logic [1:0] k, input int len,
      input bit ok, output bit hv, output logic [1:0] hc, output bit mw,
      output logic [3:0] mn, output bit cw, output bit ss);
    logic [3:0] md;
    bit st, good, en;
    hv = 0; hc = 2'b00; mw = 0; mn = 4'h0; cw = 0; ss = 0;
    if (ep >= NEP) return;
    md = m_mode[ep]; st = m_stall[ep]; mn = md;
    good = ok && (len <= 10);
    en = (md != 4'h0);
    if (k == 2'b01) begin
      if (ep == 0 && en) begin
        cw = 1;
        if (good) begin hv = 1; hc = 2'b00; mw = 1; mn = 4'h1; ss = 1; end
      end
    end else if (k == 2'b10) begin
      if (st) begin hv = 1; hc = 2'b10; end
      else case (md)
        4'h0: ;
        4'h2, 4'h3: begin hv = 1; hc = 2'b10; end
        4'h6, 4'h8, 4'hB: begin hv = 1; hc = 2'b00; mw = 1; mn = 4'h1; end
        4'hF: begin hv = 1; hc = 2'b00; mw = 1; mn = 4'h2; end
        default: begin hv = 1; hc = 2'b01; end
      endcase
    end else if (k == 2'b11) begin
      if (!good) cw = en;
      else if (st) begin hv = 1; hc = 2'b10; end
      else case (md)
        4'h0: ;
        4'h3, 4'h6: begin hv = 1; hc = 2'b10; end
        4'hB: begin hv = 1; hc = 2'b00; mw = 1; mn = 4'h8; cw = 1; end
        4'h2, 4'hF: begin
          hv = 1;
          if (len == 0) begin hc = 2'b00; mw = 1; mn = 4'h1; cw = 1; end
          else hc = 2'b10;
        end
        default: begin hv = 1; hc = 2'b01; end
      endcase
    end
  endfunction

  function automatic string tag_of(input int ep, input logic [1:0] k, input int len, input bit ok);
    if (ep >= NEP) return "R12";
    if (k == 2'b01) return "R6";
    if (k == 2'b11 && !(ok && len <= 10)) return "R5";
    if (m_stall[ep]) return "R7";
    if (m_mode[ep] == 4'h0) return "R2";
    case (m_mode[ep])
      4'h1, 4'h2, 4'h3, 4'h6, 4'h8, 4'hB, 4'hF: return (k == 2'b10) ? "R3" : "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic fw_write(input int ep, input logic [3:0] md, input bit st);
    fw_wr = 1; fw_ep = 2'(ep); fw_mode = md; fw_stall = st;
    @(posedge clk);
    if (ep < NEP && !(ep == 0 && m_pend)) begin
      m_mode[ep] = md; m_stall[ep] = (ep == 0) ? 1'b0 : st;
    end
    @(negedge clk);
    fw_wr = 0;
  endtask

  task automatic fw_read_check(input int ep, input string req);
    fw_rd = 1; fw_ep = 2'(ep);
    @(posedge clk);
    @(negedge clk);
    fw_rd = 0;
    chk(req, "rd_mode",  int'(rd_mode),  int'(m_mode[ep]));
    chk(req, "rd_stall", int'(rd_stall), int'(m_stall[ep]));
    chk(req, "rd_cnt",   int'(rd_cnt),   int'(m_cnt[ep]));
    chk(req, "rd_dval",  int'(rd_dval),  int'(m_dval[ep]));
    chk(req, "rd_tgl",   int'(rd_tgl),   int'(m_tgl[ep]));
    chk(req, "rd_setup", int'(rd_setup), (ep == 0) ? int'(m_pend) : 0);
    if (ep == 0) m_pend = 0;
  endtask

  task automatic send_ev(input int ep, input logic [1:0] k, input int len, input bit ok,
                         input bit tg);
    bit hv, mw, cw, ss;
    logic [1:0] hc;
    logic [3:0] mn;
    string req;
    req = tag_of(ep, k, len, ok);
    expect_resp(ep, k, len, ok, hv, hc, mw, mn, cw, ss);
    ev_valid = 1; ev_kind = k; ev_ep = 2'(ep); ev_len = 4'(len); ev_ok = ok; ev_tgl = tg;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 0;
    chk(req, "hs_valid", int'(hs_valid), int'(hv));
    if (hv) chk(req, "hs_code", int'(hs_code), int'(hc));
    if (ep < NEP) begin
      if (mw) m_mode[ep] = mn;
      if (cw) begin m_cnt[ep] = 4'(len); m_dval[ep] = ok && (len <= 10); m_tgl[ep] = tg; end
      if (ss) m_pend = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1; ev_valid = 0; ev_kind = 0; ev_ep = 0; ev_len = 0; ev_ok = 0; ev_tgl = 0;
    fw_wr = 0; fw_rd = 0; fw_ep = 0; fw_mode = 0; fw_stall = 0;
    for (int i = 0; i < NEP; i++) begin
      m_mode[i] = 0; m_stall[i] = 0; m_cnt[i] = 0; m_dval[i] = 0; m_tgl[i] = 0;
    end
    m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state
    chk("R1", "hs_valid after reset", int'(hs_valid), 0);
    for (int e = 0; e < NEP; e++) fw_read_check(e, "R1");

    // Sweep: endpoint x stall x mode x stimulus (R2..R7, R10, R11)
    for (int e = 0; e < NEP; e++) begin
      for (int st = 0; st < 2; st++) begin
        for (int md = 0; md < 16; md++) begin
          for (int s = 0; s < 13; s++) begin
            logic [1:0] k;
            int len;
            bit ok;
            if (s == 0)      begin k = 2'b10; len = 0; ok = 1; end
            else if (s < 9)  begin
              k = 2'b11; ok = (s % 2) == 1;
              case ((s - 1) / 2) 0: len = 0; 1: len = 3; 2: len = 10; default: len = 11; endcase
            end else begin
              k = 2'b01;
              case (s) 9: begin len = 0; ok = 1; end 10: begin len = 8; ok = 1; end
                       11: begin len = 11; ok = 1; end default: begin len = 8; ok = 0; end endcase
            end
            fw_read_check(0, "R8");
            fw_write(e, 4'(md), st[0]);
            send_ev(e, k, len, ok, s[0]);
            fw_read_check(e, "R11");
          end
        end
      end
    end

    // R8: lock while SETUP pending
    fw_read_check(0, "R8");
    fw_write(0, 4'hB, 0);
    send_ev(0, 2'b01, 8, 1, 1);
    fw_write(0, 4'h3, 0);
    fw_read_check(0, "R8");
    chk("R8", "mode kept while pending", int'(rd_mode), 1);
    fw_write(0, 4'h3, 0);
    fw_read_check(0, "R8");
    chk("R8", "write after read", int'(rd_mode), 3);
    send_ev(0, 2'b01, 4, 1, 0);

    // R9: engine vs firmware in the same cycle
    fw_read_check(0, "R9");
    fw_write(1, 4'hB, 0);
    ev_valid = 1; ev_kind = 2'b11; ev_ep = 1; ev_len = 2; ev_ok = 1; ev_tgl = 1;
    fw_wr = 1; fw_ep = 1; fw_mode = 4'h3; fw_stall = 0;
    @(posedge clk); @(negedge clk);
    ev_valid = 0; fw_wr = 0;
    chk("R9", "hs_code collision", int'(hs_code), 0);
    m_mode[1] = 4'h8; m_cnt[1] = 2; m_dval[1] = 1; m_tgl[1] = 1;
    fw_read_check(1, "R9");
    ev_valid = 1; ev_kind = 2'b11; ev_ep = 1; ev_len = 1; ev_ok = 1; ev_tgl = 0;
    fw_wr = 1; fw_ep = 1; fw_mode = 4'hF; fw_stall = 0;
    @(posedge clk); @(negedge clk);
    ev_valid = 0; fw_wr = 0;
    chk("R9", "NAK during write", int'(hs_code), 1);
    m_mode[1] = 4'hF;
    fw_read_check(1, "R9");

    // R12: endpoint number out of range
    send_ev(3, 2'b10, 0, 1, 0);
    send_ev(3, 2'b11, 0, 1, 0);
    fw_write(3, 4'h3, 1);
    for (int e = 0; e < NEP; e++) fw_read_check(e, "R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule